// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a small binary counter, four bits by default, that advances on a rising edge of one count input and retreats on a rising edge of a second count input. It has no direction pin. It lives inside one fast system clock. Both count inputs are slow strobes that are brought into that domain through two-flop synchronizers. A count step is taken only when one input rises while the other sits high.

A preset word can be forced onto the count at any time by holding the load strobe low. The output shows the preset in the same cycle, without waiting for a count edge. A clear input forces zero and wins over everything else. Two active-low terminal-count outputs act as the ripple carry and ripple borrow. Each one drops during the low half of its matching count input while the count sits at the matching end of its range. Each one rises again with that input's next rising edge. Feeding carry into the up input and borrow into the down input of a second instance builds a wider counter.

Top module: `updn_dualclk_counter`

## Requirements
- R1: A rising edge on `up_clk_i`, while `dn_clk_i` is high both before and at that edge, adds one to the count. The count output changes on the third system clock edge after the input rises.
- R2: A rising edge on `dn_clk_i`, while `up_clk_i` is high both before and at that edge, subtracts one from the count, with the same latency as R1.
- R3: The count is W bits wide (W=4 by default). Counting up from 15 gives 0, and counting down from 0 gives 15. Outside load and clear, the count moves by at most one step per system cycle.
- R4: While `load_n_i` is low and `clear_i` is low, `count_o` equals `preset_i` in the same cycle. After `load_n_i` returns high, the count keeps the last preset value.
- R5: While `clear_i` is high, `count_o` is zero, whatever `load_n_i` and `preset_i` are. The count stays zero after `clear_i` is released.
- R6: Count edges that arrive while load or clear is active are ignored. After release, the count is still the preset value (or zero).
- R7: `carry_n_o` is low exactly when the count equals its maximum (15) and the synchronized up level is low. It therefore falls two system edges after `up_clk_i` falls while the count is 15.
- R8: `borrow_n_o` is low exactly when the count is 0 and the synchronized down level is low.
- R9: If both count inputs rise in the same system cycle, the count does not change.
- R10: After the synchronous active-low reset `rst_n`, the count is 0. With both count inputs high, both terminal-count outputs are high.
- R11: A single rising edge on a count input produces a single count step, no matter how long the input then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_clk_i | input | 1 | Count-up strobe; steps on its rising edge |
| dn_clk_i | input | 1 | Count-down strobe; steps on its rising edge |
| load_n_i | input | 1 | Active-low preset load, level sensitive |
| clear_i | input | 1 | Active-high clear, overrides load |
| preset_i | input | W | Value forced while load is active |
| count_o | output | W | Current count |
| carry_n_o | output | 1 | Active-low ripple carry at maximum count |
| borrow_n_o | output | 1 | Active-low ripple borrow at zero count |

## Verification
A wrong count register shows up directly on `count_o`. It shows there three system edges after the count strobe that should have moved it, or in the same cycle when load or clear is involved. A wrong synchronizer or edge state shows as a missing step or a doubled step, which the next sample exposes. Terminal-count faults show up during the low half of a strobe at the end of the range. In the two-stage chain they also show as a wrong upper nibble, one step after the lower nibble wraps.

// File: rtl/updn_cnt_pkg.sv
// Package: updn_cnt_pkg
// Shared types for the dual-clock up/down counter.
// Assumes: nothing beyond IEEE 1800-2017.
package updn_cnt_pkg;

    // Action the count register takes in one system cycle.
    typedef enum logic [2:0] {
        STEP_HOLD  = 3'd0,
        STEP_INC   = 3'd1,
        STEP_DEC   = 3'd2,
        STEP_LOAD  = 3'd3,
        STEP_CLEAR = 3'd4
    } step_e;

endpackage

// File: rtl/updn_edge_sync.sv
// Module: updn_edge_sync
// Brings one slow strobe into the system clock domain through a flop chain
// of STAGES flops. It reports the synchronized level, the level one cycle
// earlier, and a one-cycle pulse on each low-to-high change.
// Assumes: STAGES >= 2. The strobe idles high, so the flops reset to one
// and no false edge appears when reset is released.
module updn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic level_o,
    output logic prev_o,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw strobe through the synchronizer chain.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= strobe_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Report the level and a registered-low-then-high edge.
    always_comb begin
        level_o = chain_q[STAGES-1];
        prev_o  = prev_q;
        rise_o  = chain_q[STAGES-1] & ~prev_q;
    end

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R11

endmodule

// File: rtl/updn_step_ctrl.sv
// Module: updn_step_ctrl
// Decides what the count register does this cycle. Clear wins over load,
// and load wins over counting. A count step needs the opposite strobe to be
// high both in the previous cycle and in this one.
// Assumes: edge and level inputs come from updn_edge_sync instances.
module updn_step_ctrl
    import updn_cnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_i,
    input  logic  load_n_i,
    input  logic  up_rise_i,
    input  logic  up_level_i,
    input  logic  up_prev_i,
    input  logic  dn_rise_i,
    input  logic  dn_level_i,
    input  logic  dn_prev_i,
    output step_e step_o
);

    logic up_ok;
    logic dn_ok;

    // Qualify each edge by the other strobe being held high.
    always_comb begin
        up_ok = up_rise_i & dn_level_i & dn_prev_i;
        dn_ok = dn_rise_i & up_level_i & up_prev_i;
    end

    // Pick the action, highest priority first.
    always_comb begin
        if (clear_i)        step_o = STEP_CLEAR;
        else if (!load_n_i) step_o = STEP_LOAD;
        else if (up_ok)     step_o = STEP_INC;
        else if (dn_ok)     step_o = STEP_DEC;
        else                step_o = STEP_HOLD;
    end

    AST_BOTH_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rise_i && dn_rise_i) |-> (step_o != STEP_INC && step_o != STEP_DEC)); // R9
    AST_FORCE_BLOCKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i || !load_n_i) |-> (step_o != STEP_INC && step_o != STEP_DEC)); // R6
    AST_INC_NEEDS_DN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_INC) |-> (dn_level_i && up_level_i)); // R1
    AST_DEC_NEEDS_UP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_DEC) |-> (up_level_i && dn_level_i)); // R2

endmodule

// File: rtl/updn_count_reg.sv
// Module: updn_count_reg
// Holds the W-bit count and applies the chosen action on each system edge.
// The visible count overrides the register at once while clear or load is
// active, which models the level-sensitive load and clear.
// Assumes: the step input already carries the priority order.
module updn_count_reg
    import updn_cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_e        step_i,
    input  logic         clear_i,
    input  logic         load_n_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] count_q_o,
    output logic [W-1:0] view_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_q;

    // Update the stored count from the selected action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (step_i)
                STEP_CLEAR: count_q <= '0;
                STEP_LOAD:  count_q <= preset_i;
                STEP_INC:   count_q <= count_q + ONE;
                STEP_DEC:   count_q <= count_q - ONE;
                default:    count_q <= count_q;
            endcase
        end
    end

    // Present the count, with clear and load showing through at once.
    always_comb begin
        count_q_o = count_q;
        if (clear_i)        view_o = '0;
        else if (!load_n_i) view_o = preset_i;
        else                view_o = count_q;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_q == '0)); // R5
    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_i && !clear_i) |=> (count_q == $past(preset_i))); // R4
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_i && !clear_i) |=> (count_q == $past(count_q) ||
                                    count_q == $past(count_q) + ONE ||
                                    count_q == $past(count_q) - ONE)); // R3

endmodule

// File: rtl/updn_term_count.sv
// Module: updn_term_count
// Drives the active-low ripple carry and borrow. Each one is low while the
// count sits at the matching end of its range and the matching
// synchronized strobe is low.
// Assumes: the level inputs are the synchronized strobes.
module updn_term_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count_i,
    input  logic         up_level_i,
    input  logic         dn_level_i,
    output logic         carry_n_o,
    output logic         borrow_n_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Gate each end-of-range flag with the low phase of its strobe.
    always_comb begin
        carry_n_o  = ~((count_i == TOP) & ~up_level_i);
        borrow_n_o = ~((count_i == '0)  & ~dn_level_i);
    end

    AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_i == TOP)); // R7
    AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_i == '0)); // R8

endmodule

// File: rtl/updn_dualclk_counter.sv
// Module: updn_dualclk_counter
// Top of the dual-strobe presettable up/down counter. Synchronizes both
// count strobes, chooses an action, holds the count and drives the ripple
// carry and borrow used for cascading.
// Assumes: the strobes are slower than the system clock by several cycles
// per phase. The reset is synchronous and active low.
module updn_dualclk_counter
    import updn_cnt_pkg::*;
#(
    parameter int W         = 4,
    parameter int SYNC_FLOPS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_clk_i,
    input  logic         dn_clk_i,
    input  logic         load_n_i,
    input  logic         clear_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] count_o,
    output logic         carry_n_o,
    output logic         borrow_n_o
);

    logic         up_level, up_prev, up_rise;
    logic         dn_level, dn_prev, dn_rise;
    step_e        step;
    logic [W-1:0] count_q;
    logic [W-1:0] view;

    updn_edge_sync #(.STAGES(SYNC_FLOPS)) u_up_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (up_clk_i),
        .level_o  (up_level),
        .prev_o   (up_prev),
        .rise_o   (up_rise)
    );

    updn_edge_sync #(.STAGES(SYNC_FLOPS)) u_dn_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (dn_clk_i),
        .level_o  (dn_level),
        .prev_o   (dn_prev),
        .rise_o   (dn_rise)
    );

    updn_step_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .load_n_i   (load_n_i),
        .up_rise_i  (up_rise),
        .up_level_i (up_level),
        .up_prev_i  (up_prev),
        .dn_rise_i  (dn_rise),
        .dn_level_i (dn_level),
        .dn_prev_i  (dn_prev),
        .step_o     (step)
    );

    updn_count_reg #(.W(W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .clear_i   (clear_i),
        .load_n_i  (load_n_i),
        .preset_i  (preset_i),
        .count_q_o (count_q),
        .view_o    (view)
    );

    updn_term_count #(.W(W)) u_term (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (view),
        .up_level_i (up_level),
        .dn_level_i (dn_level),
        .carry_n_o  (carry_n_o),
        .borrow_n_o (borrow_n_o)
    );

    // Drive the visible count.
    always_comb count_o = view;

    AST_CLEAR_OUTPUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |-> (count_o == '0)); // R5
    AST_STORED_MATCHES_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_i && !clear_i) |-> (count_o == count_q)); // R4

endmodule

// File: tb/tb_updn_dualclk_counter.sv
`timescale 1ns/1ps
module tb_updn_dualclk_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up = 1'b1, dn = 1'b1, ld_n = 1'b1, clr = 1'b0;
    logic [3:0] pre = 4'd0;
    logic [3:0] cnt;
    logic       carry_n, borrow_n;

    logic       cu = 1'b1, cd = 1'b1, c_ld_n = 1'b1, c_clr = 1'b0;
    logic [3:0] c_pre_lo = 4'd0, c_pre_hi = 4'd0;
    logic [3:0] lo_cnt, hi_cnt;
    logic       lo_carry_n, lo_borrow_n, hi_carry_n, hi_borrow_n;

    int checks = 0;
    int fails  = 0;
    int exp_c  = 0;

    always #5 clk = ~clk;

    updn_dualclk_counter dut (
        .clk(clk), .rst_n(rst_n), .up_clk_i(up), .dn_clk_i(dn),
        .load_n_i(ld_n), .clear_i(clr), .preset_i(pre),
        .count_o(cnt), .carry_n_o(carry_n), .borrow_n_o(borrow_n)
    );

    updn_dualclk_counter u_lo (
        .clk(clk), .rst_n(rst_n), .up_clk_i(cu), .dn_clk_i(cd),
        .load_n_i(c_ld_n), .clear_i(c_clr), .preset_i(c_pre_lo),
        .count_o(lo_cnt), .carry_n_o(lo_carry_n), .borrow_n_o(lo_borrow_n)
    );

    updn_dualclk_counter u_hi (
        .clk(clk), .rst_n(rst_n), .up_clk_i(lo_carry_n), .dn_clk_i(lo_borrow_n),
        .load_n_i(c_ld_n), .clear_i(c_clr), .preset_i(c_pre_hi),
        .count_o(hi_cnt), .carry_n_o(hi_carry_n), .borrow_n_o(hi_borrow_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One up strobe on the single instance, checking carry in the low phase.
    task automatic pulse_up();
        up = 1'b0;
        tick(4);
        chk(carry_n == ((exp_c == 15) ? 1'b0 : 1'b1), "R7 carry in low phase", carry_n, (exp_c == 15) ? 0 : 1);
        chk(borrow_n == 1'b1, "R8 borrow idle while counting up", borrow_n, 1);
        up = 1'b1;
        tick(2);
        chk(cnt == 4'(exp_c), "R1 no step before third edge", cnt, exp_c);
        tick(1);
        exp_c = (exp_c + 1) % 16;
        chk(cnt == 4'(exp_c), "R1 R3 count after up edge", cnt, exp_c);
        chk(carry_n == 1'b1, "R7 carry released", carry_n, 1);
        tick(6);
        chk(cnt == 4'(exp_c), "R11 single step per edge", cnt, exp_c);
    endtask

    // One down strobe on the single instance, checking borrow in the low phase.
    task automatic pulse_dn();
        dn = 1'b0;
        tick(4);
        chk(borrow_n == ((exp_c == 0) ? 1'b0 : 1'b1), "R8 borrow in low phase", borrow_n, (exp_c == 0) ? 0 : 1);
        chk(carry_n == 1'b1, "R7 carry idle while counting down", carry_n, 1);
        dn = 1'b1;
        tick(3);
        exp_c = (exp_c + 15) % 16;
        chk(cnt == 4'(exp_c), "R2 R3 count after down edge", cnt, exp_c);
        tick(6);
        chk(cnt == 4'(exp_c), "R11 single step per edge", cnt, exp_c);
    endtask

    initial begin
        int e8;
        tick(3);
        chk(cnt == 4'd0, "R10 count in reset", cnt, 0);
        chk(carry_n == 1'b1, "R10 carry in reset", carry_n, 1);
        chk(borrow_n == 1'b1, "R10 borrow in reset", borrow_n, 1);
        rst_n = 1'b1;
        tick(4);
        chk(cnt == 4'd0, "R10 count after reset", cnt, 0);

        // R4: exhaustive preset sweep, visible in the same cycle, kept after release.
        for (int v = 0; v < 16; v++) begin
            pre = 4'(v);
            ld_n = 1'b0;
            #1;
            chk(cnt == 4'(v), "R4 preset shows at once", cnt, v);
            tick(1);
            ld_n = 1'b1;
            pre = 4'(15 - v);
            tick(2);
            chk(cnt == 4'(v), "R4 preset held after load", cnt, v);
        end

        // R1, R3: count up from 0 across the wrap.
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
        exp_c = 0;
        for (int i = 0; i < 18; i++) pulse_up();
        // R2, R3: count down across the wrap.
        for (int i = 0; i < 20; i++) pulse_dn();

        // R5: clear beats load, holds zero after release.
        pre = 4'd9; ld_n = 1'b0; clr = 1'b1;
        #1;
        chk(cnt == 4'd0, "R5 clear overrides load", cnt, 0);
        tick(2);
        clr = 1'b0;
        #1;
        chk(cnt == 4'd9, "R4 load visible once clear drops", cnt, 9);
        ld_n = 1'b1;
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
        chk(cnt == 4'd0, "R5 zero after clear release", cnt, 0);

        // R6: edges during load are ignored.
        pre = 4'd6; ld_n = 1'b0; tick(1);
        up = 1'b0; tick(4); up = 1'b1; tick(5);
        dn = 1'b0; tick(4); dn = 1'b1; tick(5);
        ld_n = 1'b1; tick(2);
        chk(cnt == 4'd6, "R6 edges ignored during load", cnt, 6);
        // R6: edges during clear are ignored.
        clr = 1'b1;
        up = 1'b0; tick(4); up = 1'b1; tick(5);
        clr = 1'b0; tick(2);
        chk(cnt == 4'd0, "R6 edges ignored during clear", cnt, 0);

        // R9: simultaneous rises leave the count alone.
        pre = 4'd7; ld_n = 1'b0; tick(1); ld_n = 1'b1; tick(1);
        for (int i = 0; i < 3; i++) begin
            up = 1'b0; dn = 1'b0; tick(4);
            up = 1'b1; dn = 1'b1; tick(6);
            chk(cnt == 4'd7, "R9 both rise no step", cnt, 7);
        end

        // Cascade: 8-bit sequence in both directions through two chained stages.
        c_pre_lo = 4'hE; c_pre_hi = 4'hF; c_ld_n = 1'b0; tick(1); c_ld_n = 1'b1; tick(2);
        e8 = 8'hFE;
        chk({hi_cnt, lo_cnt} == 8'(e8), "R4 cascade preset", {hi_cnt, lo_cnt}, e8);
        for (int i = 0; i < 260; i++) begin
            cu = 1'b0; tick(6); cu = 1'b1; tick(10);
            e8 = (e8 + 1) % 256;
            chk({hi_cnt, lo_cnt} == 8'(e8), "R1 R7 cascade up", {hi_cnt, lo_cnt}, e8);
        end
        for (int i = 0; i < 260; i++) begin
            cd = 1'b0; tick(6); cd = 1'b1; tick(10);
            e8 = (e8 + 255) % 256;
            chk({hi_cnt, lo_cnt} == 8'(e8), "R2 R8 cascade down", {hi_cnt, lo_cnt}, e8);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule